// File: doc/BRIEF.md
# Late-Write Staging Buffer with Read Bypass

This block sits between a command interface and a single-port synchronous memory array. A write command is registered on one clock edge and its data on the next. The address and data then wait in a staging entry. They are committed to the array only when the next write command arrives. Because the array always lags one write behind, a read whose beat address matches the staged entry is served from the staging registers rather than from the array.

Transfers are single-rate (one beat per command) or double-rate (two beats per command, carried as two lanes in one clock). Beat 0 uses the command address. Beat 1 uses that address plus one, wrapping within the address space. The bypass comparison is made for each beat on its own, so a double-rate read may take one lane from the staging entry and the other from the array. Back-to-back writes are supported. A write issued directly after a read raises a one-cycle protocol error flag, and the write is still carried out.

The array is external. The block drives its per-lane addresses, lane write enables and write data, and takes its per-lane read data, which must be combinational (valid in the same cycle as the address).

Top module: `late_write_buf`

## Requirements
- R1: While `rst` is high at a clock edge, `rd_valid`, `rd_ddr`, `proto_err`, `rd_data0` and `rd_data1` are cleared, and the staging entry is emptied. After reset, `mem_wen` stays 0 until a write command is registered.
- R2: A read command registered on edge E drives `rd_valid`=1 from edge E+1 until edge E+2. It carries the data of beat 0 on `rd_data0`, and `rd_ddr` equals the command's double-rate flag.
- R3: Write data is sampled on the edge after the write command is registered: `wr_data0` always, and `wr_data1` only for a double-rate write.
- R4: A staged write is not written into the array when it is staged. It is committed in the cycle after the next write command is registered (`mem_wen` nonzero in that cycle, with `mem_addr0`/`mem_wdata0` giving the staged beat 0), and the array takes it on the edge that ends that cycle.
- R5: A read beat whose address equals a staged beat address returns the staged data instead of the array word.
- R6: The bypass is decided for each beat separately. A double-rate read may hit the staging entry on one lane and read the array on the other.
- R7: Before any write has been staged, reads return array data and no commit takes place.
- R8: `proto_err` is 1 for one cycle after a write command is registered on the edge directly following a registered read command. One idle cycle between them keeps it at 0.
- R9: The beat-1 address is the beat-0 address plus one, modulo 2^ADDR_W, for both reads and writes.
- R10: For a single-rate read, `rd_data1` is 0.
- R11: A commit enables lane 0 only (`mem_wen`=2'b01) for a single-rate staged write, and both lanes (`mem_wen`=2'b11) for a double-rate one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_ddr | input | 1 | 1 = double-rate (two beats), 0 = single-rate |
| cmd_addr | input | ADDR_W | Beat-0 address |
| wr_data0 | input | DATA_W | Write data, beat 0 (cycle after command) |
| wr_data1 | input | DATA_W | Write data, beat 1 (cycle after command) |
| rd_valid | output | 1 | Read data valid |
| rd_ddr | output | 1 | Read data holds two beats |
| rd_data0 | output | DATA_W | Read data, beat 0 |
| rd_data1 | output | DATA_W | Read data, beat 1 |
| proto_err | output | 1 | Write came directly after a read |
| mem_addr0 | output | ADDR_W | Array address, lane 0 |
| mem_addr1 | output | ADDR_W | Array address, lane 1 |
| mem_wen | output | 2 | Array write enable per lane |
| mem_wdata0 | output | DATA_W | Array write data, lane 0 |
| mem_wdata1 | output | DATA_W | Array write data, lane 1 |
| mem_rdata0 | input | DATA_W | Array read data, lane 0 (combinational) |
| mem_rdata1 | input | DATA_W | Array read data, lane 1 (combinational) |

## Verification
The assertions assume commands are fully synchronous: at most one command per edge, and inputs stable around the rising edge. They also assume the array returns read data in the same cycle as the address, so any read result is the outcome of a command sampled exactly two edges earlier. The stimulus changes inputs only on falling edges and issues one command per slot. It drives a write directly after a read only in the scenario that targets the error flag, and inserts an idle slot before a write everywhere else.

// File: rtl/lwb_pkg.sv
package lwb_pkg;

    localparam int LWB_LANES = 2;

    typedef struct packed {
        logic valid;
        logic write;
        logic ddr;
    } lwb_ctl_t;

    // lane write mask for a commit of a staged entry
    function automatic logic [LWB_LANES-1:0] lwb_lane_mask(input logic ddr);
        return {ddr, 1'b1};
    endfunction

endpackage

// File: rtl/lwb_cmd_stage.sv
module lwb_cmd_stage
    import lwb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic              cmd_ddr,
    input  logic [ADDR_W-1:0] cmd_addr,
    output lwb_ctl_t          s1_ctl,
    output logic [ADDR_W-1:0] s1_addr,
    output logic              proto_err
);

    logic prev_is_read;
    logic now_is_write;

    assign prev_is_read = s1_ctl.valid && !s1_ctl.write;
    assign now_is_write = cmd_valid && cmd_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_ctl    <= '0;
            s1_addr   <= '0;
            proto_err <= 1'b0;
        end else begin
            s1_ctl    <= '{valid: cmd_valid, write: cmd_write, ddr: cmd_ddr};
            s1_addr   <= cmd_addr;
            proto_err <= now_is_write && prev_is_read;
        end
    end

    // R8: error only reported for a write command on the previous edge
    p_err_on_write_r8: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> $past(cmd_valid && cmd_write));

endmodule

// File: rtl/lwb_stage.sv
module lwb_stage
    import lwb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  lwb_ctl_t             s1_ctl,
    input  logic [ADDR_W-1:0]    s1_addr,
    input  logic [DATA_W-1:0]    wr_data0,
    input  logic [DATA_W-1:0]    wr_data1,
    output logic                 stg_valid,
    output logic                 stg_ddr,
    output logic [ADDR_W-1:0]    stg_addr,
    output logic [DATA_W-1:0]    stg_data0,
    output logic [DATA_W-1:0]    stg_data1,
    output logic [LWB_LANES-1:0] commit_wen
);

    logic s1_is_write;

    assign s1_is_write = s1_ctl.valid && s1_ctl.write;
    assign commit_wen  = (s1_is_write && stg_valid) ? lwb_lane_mask(stg_ddr) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_valid <= 1'b0;
            stg_ddr   <= 1'b0;
            stg_addr  <= '0;
            stg_data0 <= '0;
            stg_data1 <= '0;
        end else if (s1_is_write) begin
            stg_valid <= 1'b1;
            stg_ddr   <= s1_ctl.ddr;
            stg_addr  <= s1_addr;
            stg_data0 <= wr_data0;
            stg_data1 <= s1_ctl.ddr ? wr_data1 : '0;
        end
    end

    // R11: lane 1 is never written without lane 0
    p_lane1_with_lane0_r11: assert property (@(posedge clk) disable iff (rst)
        commit_wen[1] |-> commit_wen[0]);

endmodule

// File: rtl/lwb_bypass.sv
module lwb_bypass
    import lwb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  lwb_ctl_t          s1_ctl,
    input  logic [ADDR_W-1:0] s1_addr,
    input  logic              stg_valid,
    input  logic              stg_ddr,
    input  logic [ADDR_W-1:0] stg_addr,
    input  logic [DATA_W-1:0] stg_data0,
    input  logic [DATA_W-1:0] stg_data1,
    input  logic [DATA_W-1:0] mem_rdata0,
    input  logic [DATA_W-1:0] mem_rdata1,
    output logic [ADDR_W-1:0] beat_addr0,
    output logic [ADDR_W-1:0] beat_addr1,
    output logic              rd_valid,
    output logic              rd_ddr,
    output logic [DATA_W-1:0] rd_data0,
    output logic [DATA_W-1:0] rd_data1
);

    logic              rd_req;
    logic [ADDR_W-1:0] stg_addr_hi;
    logic [ADDR_W-1:0] baddr   [LWB_LANES];
    logic [DATA_W-1:0] arr_dat [LWB_LANES];
    logic [DATA_W-1:0] sel_dat [LWB_LANES];

    assign rd_req      = s1_ctl.valid && !s1_ctl.write;
    assign stg_addr_hi = stg_addr + ADDR_W'(1);
    assign baddr[0]    = s1_addr;
    assign baddr[1]    = s1_addr + ADDR_W'(1);
    assign arr_dat[0]  = mem_rdata0;
    assign arr_dat[1]  = mem_rdata1;
    assign beat_addr0  = baddr[0];
    assign beat_addr1  = baddr[1];

    for (genvar l = 0; l < LWB_LANES; l++) begin : g_lane
        logic hit_lo;
        logic hit_hi;
        assign hit_lo = stg_valid && (baddr[l] == stg_addr);
        assign hit_hi = stg_valid && stg_ddr && (baddr[l] == stg_addr_hi);
        always_comb begin
            if (hit_lo)      sel_dat[l] = stg_data0;
            else if (hit_hi) sel_dat[l] = stg_data1;
            else             sel_dat[l] = arr_dat[l];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_ddr   <= 1'b0;
            rd_data0 <= '0;
            rd_data1 <= '0;
        end else begin
            rd_valid <= rd_req;
            rd_ddr   <= rd_req && s1_ctl.ddr;
            rd_data0 <= rd_req ? sel_dat[0] : '0;
            rd_data1 <= (rd_req && s1_ctl.ddr) ? sel_dat[1] : '0;
        end
    end

    // R10: a single-rate result leaves lane 1 quiet
    p_sdr_lane1_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ddr) |-> (rd_data1 == '0));

endmodule

// File: rtl/late_write_buf.sv
module late_write_buf
    import lwb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic                 cmd_write,
    input  logic                 cmd_ddr,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [DATA_W-1:0]    wr_data0,
    input  logic [DATA_W-1:0]    wr_data1,
    output logic                 rd_valid,
    output logic                 rd_ddr,
    output logic [DATA_W-1:0]    rd_data0,
    output logic [DATA_W-1:0]    rd_data1,
    output logic                 proto_err,
    output logic [ADDR_W-1:0]    mem_addr0,
    output logic [ADDR_W-1:0]    mem_addr1,
    output logic [LWB_LANES-1:0] mem_wen,
    output logic [DATA_W-1:0]    mem_wdata0,
    output logic [DATA_W-1:0]    mem_wdata1,
    input  logic [DATA_W-1:0]    mem_rdata0,
    input  logic [DATA_W-1:0]    mem_rdata1
);

    lwb_ctl_t             s1_ctl;
    logic [ADDR_W-1:0]    s1_addr;
    logic                 stg_valid;
    logic                 stg_ddr;
    logic [ADDR_W-1:0]    stg_addr;
    logic [DATA_W-1:0]    stg_data0;
    logic [DATA_W-1:0]    stg_data1;
    logic [LWB_LANES-1:0] commit_wen;
    logic [ADDR_W-1:0]    beat_addr0;
    logic [ADDR_W-1:0]    beat_addr1;
    logic                 committing;

    lwb_cmd_stage #(.ADDR_W(ADDR_W)) u_cmd (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_ddr(cmd_ddr), .cmd_addr(cmd_addr),
        .s1_ctl(s1_ctl), .s1_addr(s1_addr), .proto_err(proto_err)
    );

    lwb_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
        .clk(clk), .rst(rst),
        .s1_ctl(s1_ctl), .s1_addr(s1_addr),
        .wr_data0(wr_data0), .wr_data1(wr_data1),
        .stg_valid(stg_valid), .stg_ddr(stg_ddr), .stg_addr(stg_addr),
        .stg_data0(stg_data0), .stg_data1(stg_data1),
        .commit_wen(commit_wen)
    );

    lwb_bypass #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_byp (
        .clk(clk), .rst(rst),
        .s1_ctl(s1_ctl), .s1_addr(s1_addr),
        .stg_valid(stg_valid), .stg_ddr(stg_ddr), .stg_addr(stg_addr),
        .stg_data0(stg_data0), .stg_data1(stg_data1),
        .mem_rdata0(mem_rdata0), .mem_rdata1(mem_rdata1),
        .beat_addr0(beat_addr0), .beat_addr1(beat_addr1),
        .rd_valid(rd_valid), .rd_ddr(rd_ddr), .rd_data0(rd_data0), .rd_data1(rd_data1)
    );

    // one array port: a commit cycle and a read cycle never coincide
    assign committing = |commit_wen;
    assign mem_addr0  = committing ? stg_addr : beat_addr0;
    assign mem_addr1  = committing ? stg_addr + ADDR_W'(1) : beat_addr1;
    assign mem_wen    = commit_wen;
    assign mem_wdata0 = stg_data0;
    assign mem_wdata1 = stg_data1;

    // R2: read data appears two edges after the read command was sampled
    p_rd_follows_cmd_r2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(cmd_valid && !cmd_write, 2));

    // R4: the array is written only after a new write command
    p_commit_on_write_r4: assert property (@(posedge clk) disable iff (rst)
        (|mem_wen) |-> $past(cmd_valid && cmd_write));

endmodule

// File: tb/tb_late_write_buf.sv
module tb_late_write_buf;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          cmd_valid, cmd_write, cmd_ddr;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] wr_data0, wr_data1;
    logic          rd_valid, rd_ddr, proto_err;
    logic [DW-1:0] rd_data0, rd_data1;
    logic [AW-1:0] mem_addr0, mem_addr1;
    logic [1:0]    mem_wen;
    logic [DW-1:0] mem_wdata0, mem_wdata1, mem_rdata0, mem_rdata1;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    late_write_buf #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_ddr(cmd_ddr), .cmd_addr(cmd_addr),
        .wr_data0(wr_data0), .wr_data1(wr_data1),
        .rd_valid(rd_valid), .rd_ddr(rd_ddr), .rd_data0(rd_data0), .rd_data1(rd_data1),
        .proto_err(proto_err),
        .mem_addr0(mem_addr0), .mem_addr1(mem_addr1), .mem_wen(mem_wen),
        .mem_wdata0(mem_wdata0), .mem_wdata1(mem_wdata1),
        .mem_rdata0(mem_rdata0), .mem_rdata1(mem_rdata1)
    );

    // behavioural array: combinational read, write on the rising edge
    logic [DW-1:0] ram [DEPTH];
    assign mem_rdata0 = ram[mem_addr0];
    assign mem_rdata1 = ram[mem_addr1];
    always @(posedge clk) begin
        if (mem_wen[0]) ram[mem_addr0] <= mem_wdata0;
        if (mem_wen[1]) ram[mem_addr1] <= mem_wdata1;
    end

    // expected model built from the requirements
    logic [DW-1:0] exp_mem [DEPTH];
    logic          e_v = 1'b0;
    logic          e_ddr = 1'b0;
    logic [AW-1:0] e_addr = '0;
    logic [DW-1:0] e_d0 = '0, e_d1 = '0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_beat(input logic [AW-1:0] a);
        if (e_v && a == e_addr) return e_d0;
        if (e_v && e_ddr && a == AW'(e_addr + 1)) return e_d1;
        return exp_mem[a];
    endfunction

    function automatic logic [1:0] exp_wen();
        return e_v ? {e_ddr, 1'b1} : 2'b00;
    endfunction

    task automatic model_write(input logic [AW-1:0] a, input logic d, input logic [DW-1:0] x0,
                               input logic [DW-1:0] x1);
        if (e_v) begin
            exp_mem[e_addr] = e_d0;
            if (e_ddr) exp_mem[AW'(e_addr + 1)] = e_d1;
        end
        e_v = 1'b1; e_ddr = d; e_addr = a; e_d0 = x0; e_d1 = d ? x1 : '0;
    endtask

    // drive one slot and wait for the falling edge after its rising edge
    task automatic slot(input logic v, input logic w, input logic d, input logic [AW-1:0] a,
                        input logic [DW-1:0] x0, input logic [DW-1:0] x1);
        cmd_valid = v; cmd_write = w; cmd_ddr = d; cmd_addr = a;
        wr_data0 = x0; wr_data1 = x1;
        @(negedge clk);
    endtask

    task automatic idle();
        slot(1'b0, 1'b0, 1'b0, '0, '0, '0);
    endtask

    // read with idle slots around it; checks data and lane behaviour
    task automatic do_read(input logic [AW-1:0] a, input logic d, input string req);
        logic [DW-1:0] x0, x1;
        x0 = exp_beat(a);
        x1 = d ? exp_beat(AW'(a + 1)) : '0;
        slot(1'b1, 1'b0, d, a, '0, '0);
        check({req, " no commit during read"}, 32'(mem_wen), 0);
        idle();
        check({req, " R2 rd_valid"}, 32'(rd_valid), 1);
        check({req, " R2 rd_ddr"}, 32'(rd_ddr), 32'(d));
        check({req, " rd_data0"}, 32'(rd_data0), 32'(x0));
        check({req, " rd_data1"}, 32'(rd_data1), 32'(x1));
        idle();
        check({req, " R2 rd_valid drops"}, 32'(rd_valid), 0);
    endtask

    // single write followed by an idle slot; checks the commit of the older entry
    task automatic do_write(input logic [AW-1:0] a, input logic d, input logic [DW-1:0] x0,
                            input logic [DW-1:0] x1, input string req);
        logic [AW-1:0] pa; logic pv; logic [DW-1:0] pd0; logic [1:0] pw;
        pa = e_addr; pv = e_v; pd0 = e_d0; pw = exp_wen();
        slot(1'b1, 1'b1, d, a, '0, '0);
        check({req, " R11 commit lane mask"}, 32'(mem_wen), 32'(pw));
        check({req, " R8 no error after idle"}, 32'(proto_err), 0);
        if (pv) begin
            check({req, " R4 commit address"}, 32'(mem_addr0), 32'(pa));
            check({req, " R4 commit data"}, 32'(mem_wdata0), 32'(pd0));
        end
        slot(1'b0, 1'b0, 1'b0, '0, x0, x1);
        model_write(a, d, x0, x1);
        check({req, " R4 new entry not yet in array"}, 32'(ram[a]), 32'(exp_mem[a]));
        if (pv) check({req, " R4 array holds committed word"}, 32'(ram[pa]), 32'(exp_mem[pa]));
        idle();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle(); idle(); idle();
        check("R1 rd_valid", 32'(rd_valid), 0);
        check("R1 proto_err", 32'(proto_err), 0);
        check("R1 rd_data0", 32'(rd_data0), 0);
        check("R1 mem_wen", 32'(mem_wen), 0);
        rst = 1'b0;
        idle();
        check("R1 mem_wen after release", 32'(mem_wen), 0);
    endtask

    task automatic t_cold_reads();
        do_read(8'h05, 1'b0, "R7 cold sdr");
        do_read(8'h40, 1'b1, "R7 cold ddr");
        do_read(8'hFF, 1'b1, "R9 cold ddr wrap");
    endtask

    task automatic t_sdr_bypass();
        do_write(8'h10, 1'b0, 16'hA5A5, 16'hFFFF, "R3 sdr write");
        do_read(8'h10, 1'b0, "R5 sdr hit");
        do_read(8'h10, 1'b1, "R6 ddr lane0 hit lane1 array");
        do_read(8'h0F, 1'b1, "R6 ddr lane1 hit");
    endtask

    task automatic t_ddr_bypass();
        do_write(8'h20, 1'b1, 16'h1111, 16'h2222, "R11 ddr write, sdr commit");
        check("R4 sdr entry committed", 32'(ram[8'h10]), 32'h0000A5A5);
        check("R3 lane1 of sdr write ignored", 32'(ram[8'h11]), 32'(16'h1000 + 16'h11));
        do_read(8'h21, 1'b0, "R5 sdr hit on staged lane1");
        do_read(8'h20, 1'b1, "R5 ddr both lanes hit");
        do_read(8'h1F, 1'b1, "R6 R9 ddr lane1 hit");
        do_read(8'h10, 1'b0, "R4 read committed word");
    endtask

    task automatic t_wrap();
        do_write(8'hFF, 1'b1, 16'h3333, 16'h4444, "R9 ddr write wrap, ddr commit");
        check("R4 ddr lane1 committed", 32'(ram[8'h21]), 32'h00002222);
        do_read(8'h00, 1'b0, "R9 wrapped beat1 hit");
        do_read(8'hFE, 1'b1, "R9 ddr read lane1 hit");
        do_read(8'hFF, 1'b1, "R9 ddr read both hit across wrap");
    endtask

    task automatic t_back_to_back();
        logic [1:0] pw;
        pw = exp_wen();
        slot(1'b1, 1'b1, 1'b0, 8'h30, '0, '0);
        check("R11 b2b commit of ddr entry", 32'(mem_wen), 32'(pw));
        slot(1'b1, 1'b1, 1'b1, 8'h50, 16'h5555, '0);
        model_write(8'h30, 1'b0, 16'h5555, '0);
        check("R4 b2b commit of first", 32'(mem_wen), 1);
        check("R4 b2b commit address", 32'(mem_addr0), 32'h30);
        check("R4 b2b commit data", 32'(mem_wdata0), 32'h5555);
        check("R8 b2b writes no error", 32'(proto_err), 0);
        slot(1'b0, 1'b0, 1'b0, '0, 16'h6666, 16'h7777);
        model_write(8'h50, 1'b1, 16'h6666, 16'h7777);
        check("R4 b2b first now in array", 32'(ram[8'h30]), 32'h5555);
        check("R4 b2b second not in array", 32'(ram[8'h50]), 32'(16'h1000 + 16'h50));
        idle();
        do_read(8'h50, 1'b1, "R5 b2b second staged");
        do_read(8'h30, 1'b0, "R4 b2b first from array");
    endtask

    task automatic t_proto();
        logic [DW-1:0] x0;
        x0 = exp_beat(8'h60);
        slot(1'b1, 1'b0, 1'b0, 8'h60, '0, '0);
        check("R8 read alone no error", 32'(proto_err), 0);
        slot(1'b1, 1'b1, 1'b0, 8'h60, '0, '0);
        check("R8 write right after read flags error", 32'(proto_err), 1);
        check("R2 read before error completes", 32'(rd_data0), 32'(x0));
        slot(1'b0, 1'b0, 1'b0, '0, 16'h9999, '0);
        model_write(8'h60, 1'b0, 16'h9999, '0);
        check("R8 error lasts one cycle", 32'(proto_err), 0);
        idle();
        do_read(8'h60, 1'b0, "R8 write still taken");
        do_write(8'h61, 1'b0, 16'h8888, '0, "R8 write after one idle");
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            ram[i] = DW'(16'h1000 + i);
            exp_mem[i] = DW'(16'h1000 + i);
        end
        cmd_valid = 1'b0; cmd_write = 1'b0; cmd_ddr = 1'b0; cmd_addr = '0;
        wr_data0 = '0; wr_data1 = '0; rst = 1'b1;
        @(negedge clk);
        t_reset();
        t_cold_reads();
        t_sdr_bypass();
        t_ddr_bypass();
        t_wrap();
        t_back_to_back();
        t_proto();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule